// File: doc/BRIEF.md
# Synchronous Master Serial Receiver

This block receives words on a single data line while driving the shift clock itself. A programmable divider sets the shift clock, which rests high between receptions. Each bit is captured on a falling edge of that clock, least significant bit first. A word is 8 bits, or 9 when nine-bit mode is on.

Reception runs in one of two modes. A single-shot request takes one word and then withdraws itself. A continuous enable keeps taking words until it is cleared, and it wins when both are asked for. Each finished word moves from the shift register into a two-entry queue, and its ninth bit goes with it. A status flag shows that data is waiting, and an interrupt output follows that flag when its enable is set. If a word finishes while the queue is full, the word is thrown away and a sticky overrun flag is raised. That flag blocks all later queue loads until the continuous enable is dropped.

Top module: `sync_master_rx`

## Requirements
- R1: The shift clock `sclk` stays high and no word is taken unless `port_en`, `sync_mode` and `master_en` are all 1 and at least one receive enable (single or continuous) is active.
- R2: The shift clock period is 4×(`div_val`+1) system clocks. Each bit starts with a falling edge that samples `sdata`, followed by a low half and a high half of 2×(`div_val`+1) clocks each. Bits arrive LSB first, so the first sampled bit becomes `rx_data[0]`.
- R3: A pulse on `single_set` (with `cont_en` low) receives exactly one word. `single_busy` then returns to 0 and `sclk` rests high.
- R4: While `cont_en` is 1, words are received back to back. Clearing it stops reception, and a partly shifted word is dropped.
- R5: When both the single request and `cont_en` are active, reception continues past the first word.
- R6: The queue holds two words in arrival order. `rx_data` shows the oldest entry, and a `rd_strobe` pulse removes it.
- R7: `rx_flag` is 1 whenever the queue holds at least one word and goes to 0 only once reads have emptied it. `irq` equals `rx_flag` when `irq_en` is 1 and is 0 otherwise.
- R8: If a word completes while both queue entries are full, `ovr_err` becomes 1 and that word is discarded.
- R9: While `ovr_err` is 1, no word enters the queue, even after reads. `ovr_err` clears on the cycle after `cont_en` falls.
- R10: With `nine_bit`=1, each queue entry keeps its own ninth bit, and `rx_bit9` shows the ninth bit of the entry at the head. With `nine_bit`=0, `rx_bit9` reads 0.
- R11: With `port_en` low, the queue empties, `ovr_err` and `single_busy` are 0, and `sclk` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Port enable; low clears all state |
| sync_mode | input | 1 | Synchronous mode select |
| master_en | input | 1 | Clock-master select |
| nine_bit | input | 1 | 9-bit word mode |
| single_set | input | 1 | Pulse requesting one word |
| cont_en | input | 1 | Continuous receive enable |
| div_val | input | DIV_W | Shift clock divider value |
| irq_en | input | 1 | Interrupt enable |
| rd_strobe | input | 1 | Pop the head queue entry |
| sdata | input | 1 | Serial data in |
| sclk | output | 1 | Generated shift clock |
| single_busy | output | 1 | Single request pending |
| rx_data | output | WORD_W | Head entry data |
| rx_bit9 | output | 1 | Head entry ninth bit |
| rx_flag | output | 1 | Queue not empty |
| ovr_err | output | 1 | Sticky overrun |
| irq | output | 1 | Gated receive interrupt |

## Verification
The bench builds the block with its default parameters: an 8-bit divider and 8-bit data words. At run time it uses divider values 0 and 2. The value 2 makes the phase lengths uneven enough that an off-by-one in the half-period count shows up. The value 0 keeps each word at 32 clocks, so three or four words fit inside one test. That makes it practical to fill the queue, force an overrun and watch a fourth word being blocked. A bench-side slave shifts out known patterns, which checks bit order and the per-entry ninth bit against fixed expected words.

// File: rtl/sync_master_rx.sv
module sync_master_rx #(
  parameter int DIV_W  = 8,
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_en,
  input  logic              sync_mode,
  input  logic              master_en,
  input  logic              nine_bit,
  input  logic              single_set,
  input  logic              cont_en,
  input  logic [DIV_W-1:0]  div_val,
  input  logic              irq_en,
  input  logic              rd_strobe,
  input  logic              sdata,
  output logic              sclk,
  output logic              single_busy,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_bit9,
  output logic              rx_flag,
  output logic              ovr_err,
  output logic              irq
);
  localparam int BIT_W = $clog2(WORD_W + 1);

  logic [DIV_W:0]  cnt;
  logic [BIT_W-1:0] bitn;
  logic [WORD_W:0] sr;
  logic [WORD_W:0] mem [2];
  logic            running, single_en, ovr, cont_q, head;
  logic [1:0]      count;

  wire [DIV_W:0]   half_end = {div_val, 1'b1};
  wire             cfg_ok   = port_en & sync_mode & master_en;
  wire             go       = cfg_ok & (cont_en | single_en);
  wire [BIT_W-1:0] last_bit = nine_bit ? BIT_W'(WORD_W) : BIT_W'(WORD_W - 1);
  wire             half_done = running && (cnt == half_end);
  wire             word_done = half_done && sclk && (bitn == last_bit);
  wire             pop      = rd_strobe && (count != 2'd0);
  wire             room     = (count != 2'd2) || pop;
  wire             push     = word_done && !ovr && room;
  wire             ovr_set  = word_done && !ovr && !room;
  wire             tail     = head ^ count[0];

  assign rx_data     = mem[head][WORD_W-1:0];
  assign rx_bit9     = mem[head][WORD_W];
  assign rx_flag     = (count != 2'd0);
  assign irq         = rx_flag & irq_en;
  assign ovr_err     = ovr;
  assign single_busy = single_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; bitn <= '0; sr <= '0; running <= 1'b0; sclk <= 1'b1;
      single_en <= 1'b0; ovr <= 1'b0; cont_q <= 1'b0; head <= 1'b0; count <= 2'd0;
      mem[0] <= '0; mem[1] <= '0;
    end else if (!port_en) begin
      cnt <= '0; bitn <= '0; sr <= '0; running <= 1'b0; sclk <= 1'b1;
      single_en <= 1'b0; ovr <= 1'b0; cont_q <= 1'b0; head <= 1'b0; count <= 2'd0;
    end else begin
      cont_q    <= cont_en;
      single_en <= (single_en & ~word_done) | single_set;
      if (cont_q && !cont_en) ovr <= 1'b0;
      else if (ovr_set)       ovr <= 1'b1;

      if (!running) begin
        if (go) begin
          running <= 1'b1; sclk <= 1'b0; cnt <= '0; bitn <= '0; sr[0] <= sdata;
        end
      end else if (!go) begin
        running <= 1'b0; sclk <= 1'b1; cnt <= '0;
      end else if (cnt != half_end) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        if (!sclk) sclk <= 1'b1;
        else if (bitn != last_bit) begin
          bitn <= bitn + 1'b1; sclk <= 1'b0; sr[bitn + 1'b1] <= sdata;
        end else if (cont_en) begin
          bitn <= '0; sclk <= 1'b0; sr[0] <= sdata;
        end else running <= 1'b0;
      end

      if (push) mem[tail] <= {nine_bit & sr[WORD_W], sr[WORD_W-1:0]};
      if (pop)  head <= ~head;
      count <= count + {1'b0, push} - {1'b0, pop};
    end
  end

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> sclk);
  assert_single_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && !single_set) |=> !single_busy);
  assert_count_max_R6: assert property (@(posedge clk) disable iff (!rst_n)
    count <= 2'd2);
  assert_ovr_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && ovr && cont_en) |=> ovr_err);
  assert_no_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |=> count <= $past(count));
  assert_disable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> (!rx_flag && !ovr_err && sclk && !single_busy));
endmodule

// File: tb/test_sync_master_rx.sv
`timescale 1ns/1ps
module test_sync_master_rx;
  logic clk = 0, rst_n = 0;
  logic port_en = 0, sync_mode = 0, master_en = 0, nine_bit = 0;
  logic single_set = 0, cont_en = 0, irq_en = 0, rd_strobe = 0;
  logic [7:0] div_val = 0;
  logic sdata, sclk, single_busy, rx_bit9, rx_flag, ovr_err, irq;
  logic [7:0] rx_data;
  int tests = 0, fails = 0;

  logic [8:0] sw [0:7];
  int bidx = 0, widx = 0, nbits = 8;
  assign sdata = sw[widx & 7][bidx];

  always #2 clk = ~clk;

  always @(posedge sclk) begin
    if (bidx == nbits - 1) begin bidx = 0; widx = widx + 1; end
    else bidx = bidx + 1;
  end

  sync_master_rx i_sync_master_rx (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .sync_mode(sync_mode),
    .master_en(master_en), .nine_bit(nine_bit), .single_set(single_set),
    .cont_en(cont_en), .div_val(div_val), .irq_en(irq_en), .rd_strobe(rd_strobe),
    .sdata(sdata), .sclk(sclk), .single_busy(single_busy), .rx_data(rx_data),
    .rx_bit9(rx_bit9), .rx_flag(rx_flag), .ovr_err(ovr_err), .irq(irq));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask

  task automatic rd();
    rd_strobe = 1; cyc(1); rd_strobe = 0;
  endtask

  task automatic slave_reset(int nb);
    bidx = 0; widx = 0; nbits = nb;
  endtask

  task automatic cfg_on();
    port_en = 1; sync_mode = 1; master_en = 1;
  endtask

  task automatic flush();
    cont_en = 0; port_en = 0; cyc(2); cfg_on(); cyc(1);
  endtask

  task automatic t_reset();
    chk("R11 reset sclk", sclk, 1);
    chk("R11 reset flag", rx_flag, 0);
    chk("R11 reset ovr", ovr_err, 0);
    chk("R7 reset irq", irq, 0);
  endtask

  task automatic t_no_cfg_R1();
    int falls = 0;
    port_en = 1; sync_mode = 0; master_en = 1; cont_en = 1;
    for (int i = 0; i < 60; i++) begin cyc(1); if (sclk !== 1) falls++; end
    chk("R1 sclk idle without sync", falls, 0);
    chk("R1 no word", rx_flag, 0);
    cont_en = 0; cyc(2);
  endtask

  task automatic t_clock_R2_R3();
    int low = 0, per = 0, t = 0;
    cfg_on(); div_val = 2; sw[0] = 9'h0A5; slave_reset(8);
    single_set = 1; cyc(1); single_set = 0;
    while (sclk !== 0 && t < 100) begin cyc(1); t++; end
    while (sclk === 0 && low < 100) begin low++; cyc(1); end
    per = low;
    while (sclk === 1 && per < 100) begin per++; cyc(1); end
    chk("R2 low half", low, 6);
    chk("R2 period", per, 12);
    t = 0;
    while (!rx_flag && t < 400) begin cyc(1); t++; end
    chk("R2 LSB-first data", rx_data, 8'hA5);
    cyc(150);
    chk("R3 single_busy cleared", single_busy, 0);
    chk("R3 sclk rests high", sclk, 1);
    rd();
    chk("R3 only one word", rx_flag, 0);
    div_val = 0;
  endtask

  task automatic t_cont_R4_R6();
    sw[0] = 9'h011; sw[1] = 9'h0C2; sw[2] = 9'h0FF; slave_reset(8);
    cont_en = 1; cyc(70); cont_en = 0; cyc(40);
    chk("R6 head oldest", rx_data, 8'h11);
    chk("R4 no overrun after abort", ovr_err, 0);
    rd();
    chk("R7 flag holds with one left", rx_flag, 1);
    chk("R6 second word", rx_data, 8'hC2);
    rd();
    chk("R4 partial word dropped", rx_flag, 0);
  endtask

  task automatic t_both_R5();
    sw[0] = 9'h033; sw[1] = 9'h044; slave_reset(8);
    cont_en = 1; single_set = 1; cyc(1); single_set = 0;
    cyc(70); cont_en = 0; cyc(2);
    chk("R5 first word", rx_data, 8'h33);
    rd();
    chk("R5 continues past first", rx_flag, 1);
    chk("R5 second word", rx_data, 8'h44);
    rd(); flush();
  endtask

  task automatic t_ovr_R8_R9();
    sw[0] = 9'h0A1; sw[1] = 9'h0B2; sw[2] = 9'h0C3; sw[3] = 9'h0D4; slave_reset(8);
    cont_en = 1; cyc(100);
    chk("R8 overrun set", ovr_err, 1);
    chk("R8 head kept", rx_data, 8'hA1);
    rd();
    chk("R8 third dropped", rx_data, 8'hB2);
    rd();
    cyc(40);
    chk("R9 no load while overrun", rx_flag, 0);
    chk("R9 overrun sticky", ovr_err, 1);
    cont_en = 0; cyc(2);
    chk("R9 cleared by cont_en fall", ovr_err, 0);
    flush();
  endtask

  task automatic t_nine_R10();
    nine_bit = 1; sw[0] = 9'h1A3; sw[1] = 9'h05C; slave_reset(9);
    cont_en = 1; cyc(80); cont_en = 0; cyc(2);
    chk("R10 bit9 first", rx_bit9, 1);
    chk("R10 data first", rx_data, 8'hA3);
    rd();
    chk("R10 bit9 second", rx_bit9, 0);
    chk("R10 data second", rx_data, 8'h5C);
    rd(); flush();
    nine_bit = 0; sw[0] = 9'h1FF; sw[1] = 9'h1FF; slave_reset(8);
    single_set = 1; cyc(1); single_set = 0; cyc(60);
    chk("R10 8-bit bit9 zero", rx_bit9, 0);
    chk("R10 8-bit data", rx_data, 8'hFF);
  endtask

  task automatic t_irq_R7();
    irq_en = 0; cyc(1);
    chk("R7 irq gated off", irq, 0);
    irq_en = 1; cyc(1);
    chk("R7 irq on", irq, 1);
    rd();
    chk("R7 flag cleared on empty", rx_flag, 0);
    chk("R7 irq cleared", irq, 0);
    irq_en = 0;
  endtask

  task automatic t_disable_R11();
    sw[0] = 9'h001; sw[1] = 9'h002; sw[2] = 9'h003; slave_reset(8);
    cont_en = 1; cyc(100);
    chk("R11 precondition ovr", ovr_err, 1);
    port_en = 0; cyc(2);
    chk("R11 flag cleared", rx_flag, 0);
    chk("R11 ovr cleared", ovr_err, 0);
    chk("R11 sclk high", sclk, 1);
    single_set = 1; cyc(1); single_set = 0; cyc(1);
    chk("R11 single ignored", single_busy, 0);
    cont_en = 0;
  endtask

  initial begin
    for (int i = 0; i < 8; i++) sw[i] = '0;
    cyc(3); rst_n = 1; cyc(2);
    t_reset();
    t_no_cfg_R1();
    t_clock_R2_R3();
    t_cont_R4_R6();
    t_both_R5();
    t_ovr_R8_R9();
    t_nine_R10();
    t_irq_R7();
    t_disable_R11();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule